// File: doc/BRIEF.md
# Interrupt Vector Responder

This block gathers interrupt requests from peripheral sources across several priority levels. Each level has a fixed number of request bits. It drives a summary request line per level toward the system. When the system acknowledges a level, the block answers one cycle later with an interrupt vector. Sources raise their bit with a single-cycle set strobe. Answering an acknowledge retires one request: either the adapter's own error interrupt or the lowest-numbered device bit pending on that level.

The adapter's own error interrupt takes precedence over device requests on every level that the external control register enables. On those levels it answers with the control register's vector. A device answer is the programmable vector offset ORed with that source's entry in a programmable per-source table. A level with nothing pending answers with the offset alone. The offset register keeps only a five-bit window of the written value.

Top module: `intr_vector_responder`

## Requirements
- R1: A set strobe on bit `req_set[l*32+s]` makes source s of level l pending from the next cycle on. When that bit is also retired by an acknowledge in the same cycle, it stays pending.
- R2: The vector offset register stores only bits 13:9 of `ofs_wr_data`. `ofs_rd` shows the stored value from the cycle after the write, and all its other bits read zero.
- R3: An acknowledge of level l while the adapter interrupt is pending and `ctl_lvl_mask[l]` is 1 answers `ctl_vector`. It clears the adapter pending flag unless `adp_int_set` is high in the same cycle. No device bit changes.
- R4: Otherwise the acknowledge retires the lowest-numbered pending bit s of level l. It answers `ofs_rd | table[l*32+s]`, where the table entry at index `{level, source}` is written through `tbl_wr_*`.
- R5: An acknowledge of a level with no device bit pending, and no adapter answer due, returns the vector offset alone.
- R6: `vec_valid` is high exactly in the cycle after an `ack_valid` cycle. `vec_out` then carries that acknowledge's vector.
- R7: While the adapter interrupt is pending, `lvl_req[l]` is 1 for every level l with `ctl_lvl_mask[l]` = 1.
- R8: With no adapter interrupt pending, `lvl_req[l]` equals the OR of the pending bits of level l.
- R9: Reset clears all pending bits, the adapter pending flag, the vector offset, `vec_valid` and all `lvl_req` bits.
- R10: An acknowledge of one level leaves the pending bits of every other level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NUM_LEVELS*SRC_PER_LEVEL | Single-cycle set strobes, bit l*SRC_PER_LEVEL+s for source s of level l |
| tbl_wr_en | input | 1 | Write strobe for the per-source vector table |
| tbl_wr_idx | input | IDX_W | Table index {level, source} |
| tbl_wr_vec | input | VEC_W | Table entry value |
| ofs_wr_en | input | 1 | Write strobe for the vector offset register |
| ofs_wr_data | input | VEC_W | Offset write value (only bits 13:9 kept) |
| ofs_rd | output | VEC_W | Current vector offset |
| ctl_lvl_mask | input | NUM_LEVELS | Levels on which the adapter interrupt is raised |
| ctl_vector | input | VEC_W | Vector answered for the adapter interrupt |
| adp_int_set | input | 1 | Raises the adapter error interrupt |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | LVL_W | Level being acknowledged |
| vec_valid | output | 1 | Vector answer valid |
| vec_out | output | VEC_W | Vector answer |
| lvl_req | output | NUM_LEVELS | Per-level request summary |

## Verification
The bench builds the block with its default values: four levels of 32 sources, 16-bit vectors and the offset window at bits 13:9. With these values every request bit gets a distinct table entry. This makes an answer from the wrong source, or from the wrong level, visible in the vector value. The extreme bit positions 0 and 31 are reachable, and so is the case where the adapter's enabled levels and the device levels differ. A pseudo-random phase mixes set strobes, acknowledges and adapter raises, so set-versus-retire collisions on the same bit also occur.

// File: rtl/ivr_pkg.sv
`timescale 1ns/1ps
package ivr_pkg;

  // Source of an acknowledge answer, brought out for the assertions
  typedef enum logic [1:0] {
    ACK_IDLE    = 2'd0,
    ACK_ADAPTER = 2'd1,
    ACK_DEVICE  = 2'd2,
    ACK_EMPTY   = 2'd3
  } ack_kind_e;

  // Mask with ones from bit lo to bit hi inclusive
  function automatic logic [31:0] window_mask(input int unsigned lo, input int unsigned hi);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Device answer: offset merged with a table entry
  function automatic logic [31:0] merge_vector(input logic [31:0] ofs, input logic [31:0] entry);
    return ofs | entry;
  endfunction

endpackage

// File: rtl/ivr_level_bank.sv
`timescale 1ns/1ps
module ivr_level_bank #(
  parameter int SRC   = 32,
  parameter int SRC_W = $clog2(SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC-1:0]   set_strb,
  input  logic             clr_en,
  output logic [SRC-1:0]   pend,
  output logic             any,
  output logic [SRC_W-1:0] first_idx
);

  // Lowest-numbered set bit; zero when none
  function automatic logic [SRC_W-1:0] lowest_idx(input logic [SRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = SRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRC_W'(i);
    end
    return r;
  endfunction

  logic [SRC-1:0] clr_mask;
  logic [SRC-1:0] pend_nxt;

  assign any       = |pend;
  assign first_idx = lowest_idx(pend);
  assign clr_mask  = clr_en ? (SRC'(1) << first_idx) : '0;
  assign pend_nxt  = (pend & ~clr_mask) | set_strb;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  // R1
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_strb != '0) |=> ((pend & $past(set_strb)) == $past(set_strb)));

  // R4
  clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && any && set_strb == '0) |=> ($countones(pend) == $countones($past(pend)) - 1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && set_strb == '0) |=> $stable(pend));

endmodule

// File: rtl/ivr_vector_table.sv
`timescale 1ns/1ps
module ivr_vector_table #(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int VEC_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VEC_W-1:0] rd_vec
);

  logic [VEC_W-1:0] entry [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) entry[i] <= '0;
    end else if (wr_en) begin
      entry[wr_idx] <= wr_vec;
    end
  end

  assign rd_vec = entry[rd_idx];

endmodule

// File: rtl/intr_vector_responder.sv
`timescale 1ns/1ps
module intr_vector_responder
  import ivr_pkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int SRC_PER_LEVEL = 32,
  parameter int VEC_W         = 16,
  parameter int OFS_LSB       = 9,
  parameter int OFS_MSB       = 13,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int SRC_W        = $clog2(SRC_PER_LEVEL),
  localparam int IDX_W        = LVL_W + SRC_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_LEVELS*SRC_PER_LEVEL-1:0] req_set,
  input  logic                                tbl_wr_en,
  input  logic [IDX_W-1:0]                    tbl_wr_idx,
  input  logic [VEC_W-1:0]                    tbl_wr_vec,
  input  logic                                ofs_wr_en,
  input  logic [VEC_W-1:0]                    ofs_wr_data,
  output logic [VEC_W-1:0]                    ofs_rd,
  input  logic [NUM_LEVELS-1:0]               ctl_lvl_mask,
  input  logic [VEC_W-1:0]                    ctl_vector,
  input  logic                                adp_int_set,
  input  logic                                ack_valid,
  input  logic [LVL_W-1:0]                    ack_level,
  output logic                                vec_valid,
  output logic [VEC_W-1:0]                    vec_out,
  output logic [NUM_LEVELS-1:0]               lvl_req
);

  localparam int ENTRIES            = NUM_LEVELS * SRC_PER_LEVEL;
  localparam logic [31:0] OFS_WIN   = window_mask(OFS_LSB, OFS_MSB);
  localparam logic [VEC_W-1:0] OFS_KEEP = OFS_WIN[VEC_W-1:0];

  // Per-level state brought out as named wires
  logic [SRC_PER_LEVEL-1:0] lvl_pend  [NUM_LEVELS];
  logic [SRC_W-1:0]         lvl_first [NUM_LEVELS];
  logic [NUM_LEVELS-1:0]    lvl_any;
  logic [NUM_LEVELS-1:0]    lvl_clr;

  logic                     adp_pend;
  logic                     adapter_hit;
  ack_kind_e                ack_kind;
  logic [IDX_W-1:0]         tbl_rd_idx;
  logic [VEC_W-1:0]         tbl_rd_vec;
  logic [VEC_W-1:0]         vec_nxt;
  logic [VEC_W-1:0]         ofs_q;

  // ---------------- request banks ----------------
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    ivr_level_bank #(
      .SRC   (SRC_PER_LEVEL),
      .SRC_W (SRC_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_strb  (req_set[l*SRC_PER_LEVEL +: SRC_PER_LEVEL]),
      .clr_en    (lvl_clr[l]),
      .pend      (lvl_pend[l]),
      .any       (lvl_any[l]),
      .first_idx (lvl_first[l])
    );
    assign lvl_clr[l] = (ack_kind == ACK_DEVICE) && (ack_level == LVL_W'(l));
    assign lvl_req[l] = (adp_pend & ctl_lvl_mask[l]) | lvl_any[l];
  end

  // ---------------- vector table ----------------
  assign tbl_rd_idx = {ack_level, lvl_first[ack_level]};

  ivr_vector_table #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .VEC_W   (VEC_W)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr_en),
    .wr_idx (tbl_wr_idx),
    .wr_vec (tbl_wr_vec),
    .rd_idx (tbl_rd_idx),
    .rd_vec (tbl_rd_vec)
  );

  // ---------------- offset register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n)         ofs_q <= '0;
    else if (ofs_wr_en) ofs_q <= ofs_wr_data & OFS_KEEP;
  end
  assign ofs_rd = ofs_q;

  // ---------------- acknowledge decision ----------------
  assign adapter_hit = adp_pend && ctl_lvl_mask[ack_level];

  always_comb begin
    if (!ack_valid)               ack_kind = ACK_IDLE;
    else if (adapter_hit)         ack_kind = ACK_ADAPTER;
    else if (lvl_any[ack_level])  ack_kind = ACK_DEVICE;
    else                          ack_kind = ACK_EMPTY;
  end

  always_comb begin
    case (ack_kind)
      ACK_ADAPTER: vec_nxt = ctl_vector;
      ACK_DEVICE:  vec_nxt = VEC_W'(merge_vector(32'(ofs_q), 32'(tbl_rd_vec)));
      default:     vec_nxt = ofs_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adp_pend  <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      if (adp_int_set)                  adp_pend <= 1'b1;
      else if (ack_kind == ACK_ADAPTER) adp_pend <= 1'b0;
      vec_valid <= ack_valid;
      if (ack_valid) vec_out <= vec_nxt;
    end
  end

  // R6
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> vec_valid);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !vec_valid);

  // R3
  adp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && adp_pend && ctl_lvl_mask[ack_level] && !adp_int_set) |=> !adp_pend);

  // R3
  adp_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && adp_pend && ctl_lvl_mask[ack_level]) |=> (vec_out == $past(ctl_vector)));

  // R5
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !adapter_hit && lvl_pend[ack_level] == '0) |=> (vec_out == $past(ofs_rd)));

  // R2
  ofs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_wr_en |=> (ofs_rd == ($past(ofs_wr_data) & OFS_KEEP)));

  // R7
  summary_adp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adp_pend |-> ((lvl_req & ctl_lvl_mask) == ctl_lvl_mask));

  // R8
  summary_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adp_pend |-> (lvl_req == lvl_any));

  // R9
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!vec_valid && !adp_pend && ofs_rd == '0));

endmodule

// File: tb/intr_vector_responder_bench.sv
`timescale 1ns/1ps
module intr_vector_responder_bench;

  localparam int NL  = 4;
  localparam int NS  = 32;
  localparam int VW  = 16;
  localparam logic [15:0] KEEP = 16'h3E00;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL*NS-1:0] req_set = '0;
  logic            tbl_wr_en = 1'b0;
  logic [6:0]      tbl_wr_idx = '0;
  logic [VW-1:0]   tbl_wr_vec = '0;
  logic            ofs_wr_en = 1'b0;
  logic [VW-1:0]   ofs_wr_data = '0;
  logic [VW-1:0]   ofs_rd;
  logic [NL-1:0]   ctl_lvl_mask = '0;
  logic [VW-1:0]   ctl_vector = '0;
  logic            adp_int_set = 1'b0;
  logic            ack_valid = 1'b0;
  logic [1:0]      ack_level = '0;
  logic            vec_valid;
  logic [VW-1:0]   vec_out;
  logic [NL-1:0]   lvl_req;

  always #2.5 clk = ~clk;

  intr_vector_responder u_intr_vector_responder (
    .clk(clk), .rst_n(rst_n), .req_set(req_set),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_vec(tbl_wr_vec),
    .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data), .ofs_rd(ofs_rd),
    .ctl_lvl_mask(ctl_lvl_mask), .ctl_vector(ctl_vector), .adp_int_set(adp_int_set),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .vec_valid(vec_valid), .vec_out(vec_out), .lvl_req(lvl_req)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [VW-1:0] vec; string tag; } exp_t;
  exp_t sb_q[$];

  // reference model
  logic [NS-1:0] m_pend [NL];
  logic          m_adp;
  logic [VW-1:0] m_ofs;
  logic [VW-1:0] m_tbl [NL*NS];

  function automatic logic [VW-1:0] tbl_value(input int i);
    return VW'(i * 4) ^ 16'hC001;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NL; l++) m_pend[l] = '0;
    m_adp = 1'b0;
    m_ofs = '0;
    for (int i = 0; i < NL*NS; i++) m_tbl[i] = '0;
  endtask

  function automatic logic [NL-1:0] model_summary();
    logic [NL-1:0] s;
    for (int l = 0; l < NL; l++) s[l] = (m_adp & ctl_lvl_mask[l]) | (|m_pend[l]);
    return s;
  endfunction

  // Driver: one cycle of stimulus; pushes the expected answer on acknowledge
  task automatic step(input logic [NL*NS-1:0] s, input bit ack, input int lvl,
                      input bit aset, input string tag);
    exp_t e;
    if (ack) begin
      e.tag = tag;
      if (m_adp && ctl_lvl_mask[lvl]) begin
        e.vec = ctl_vector;
        m_adp = 1'b0;
      end else begin
        e.vec = m_ofs;
        for (int b = 0; b < NS; b++) begin
          if (m_pend[lvl][b]) begin
            e.vec = m_ofs | m_tbl[lvl*NS + b];
            m_pend[lvl][b] = 1'b0;
            break;
          end
        end
      end
      sb_q.push_back(e);
    end
    if (aset) m_adp = 1'b1;
    for (int l = 0; l < NL; l++) m_pend[l] = m_pend[l] | s[l*NS +: NS];
    req_set = s; ack_valid = ack; ack_level = 2'(lvl); adp_int_set = aset;
    @(negedge clk);
    req_set = '0; ack_valid = 1'b0; adp_int_set = 1'b0;
    check(lvl_req == model_summary(), "R7/R8 summary", 32'(lvl_req), 32'(model_summary()));
  endtask

  function automatic logic [NL*NS-1:0] bit_at(input int lvl, input int src);
    logic [NL*NS-1:0] v;
    v = '0;
    v[lvl*NS + src] = 1'b1;
    return v;
  endfunction

  task automatic write_ofs(input logic [VW-1:0] d, input string tag);
    ofs_wr_en = 1'b1; ofs_wr_data = d;
    @(negedge clk);
    ofs_wr_en = 1'b0;
    m_ofs = d & KEEP;
    check(ofs_rd == m_ofs, tag, 32'(ofs_rd), 32'(m_ofs));
  endtask

  // Monitor: compares answers in order
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 unexpected vec_valid", 32'(vec_out), 32'hX);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(vec_out == e.vec, e.tag, 32'(vec_out), 32'(e.vec));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  logic [31:0] rng = 32'h1ACE_B00C;
  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(lvl_req == '0, "R9 reset lvl_req", 32'(lvl_req), 0);
    check(vec_valid == 1'b0, "R9 reset vec_valid", 32'(vec_valid), 0);
    check(ofs_rd == '0, "R9 reset ofs_rd", 32'(ofs_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: offset window
    write_ofs(16'hFFFF, "R2 offset all ones");
    write_ofs(16'h1234, "R2 offset partial");

    // program the table
    for (int i = 0; i < NL*NS; i++) begin
      tbl_wr_en = 1'b1; tbl_wr_idx = 7'(i); tbl_wr_vec = tbl_value(i);
      m_tbl[i] = tbl_value(i);
      @(negedge clk);
    end
    tbl_wr_en = 1'b0;

    // R4 / R5 / R10: lowest first, empty returns offset
    step(bit_at(1, 20) | bit_at(1, 5) | bit_at(2, 9), 0, 0, 0, "R1 set");
    step('0, 1, 1, 0, "R4 level1 lowest src5");
    step('0, 1, 1, 0, "R4 level1 src20");
    step('0, 1, 1, 0, "R5 level1 empty");
    step('0, 1, 2, 0, "R10 level2 untouched src9");
    step(bit_at(3, 31) | bit_at(3, 0), 0, 0, 0, "R1 set edges");
    step('0, 1, 3, 0, "R4 level3 bit0");
    step('0, 1, 3, 0, "R4 level3 bit31");
    step('0, 1, 0, 0, "R5 level0 empty");

    // R1: set wins over same-cycle retire
    step(bit_at(0, 7), 0, 0, 0, "R1 set src7");
    step(bit_at(0, 7), 1, 0, 0, "R1 collision");
    step('0, 1, 0, 0, "R1 still pending after collision");

    // R3 / R7: adapter interrupt
    ctl_lvl_mask = 4'b0101;
    ctl_vector = 16'h0154;
    step(bit_at(2, 3) | bit_at(1, 4), 0, 0, 1, "R7 adapter raise");
    step('0, 1, 1, 0, "R3 non-enabled level gives device");
    step('0, 1, 2, 0, "R3 adapter vector on level2");
    step('0, 1, 2, 0, "R4 level2 device after adapter");
    step('0, 0, 0, 1, "R7 raise again");
    step('0, 1, 0, 1, "R3 raise and retire same cycle");
    step('0, 1, 0, 0, "R3 adapter vector level0");
    step('0, 1, 0, 0, "R5 after adapter cleared");

    // mixed pseudo-random phase
    ctl_lvl_mask = 4'b1010;
    ctl_vector = 16'h2AA8;
    for (int n = 0; n < 600; n++) begin
      logic [NL*NS-1:0] s;
      rng = next_rng(rng);
      s = '0;
      if (rng[0]) s = s | bit_at(int'(rng[2:1]), int'(rng[7:3]));
      if (rng[8] && rng[9]) s = s | bit_at(int'(rng[11:10]), int'(rng[16:12]));
      step(s, rng[17] | rng[18], int'(rng[20:19]), (rng[27:24] == 4'h0), "R4 mixed");
      if (n == 300) write_ofs(16'hA5C3, "R2 offset mid-run");
    end

    // R9: reset mid-run clears state
    step(bit_at(0, 1) | bit_at(3, 2), 0, 0, 1, "R1 set before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < NL*NS; i++) m_tbl[i] = '0;
    check(lvl_req == '0, "R9 lvl_req after reset", 32'(lvl_req), 0);
    check(ofs_rd == '0, "R9 ofs_rd after reset", 32'(ofs_rd), 0);
    step('0, 1, 3, 0, "R9 empty after reset");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R6 missing answers", 32'(sb_q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule